// File: doc/BRIEF.md
# Row-Buffered Burst Column Engine

This block runs fixed-length bursts against a small row-organised word store. A caller presents one request made of a row number, a starting column and a direction (read or write). The row stays open for the whole burst. An internal column counter then walks the columns, one word per rising clock edge, and the caller supplies no further address bits. A small mode register sets the burst length. Its smallest setting turns bursting off, so each request moves a single word.

The column counter never leaves the block of columns aligned to the burst length. A burst that starts in the middle of a block wraps back to the start of that block. While a burst runs, the engine reports busy and ignores new requests and mode loads. Read data comes with a valid flag that is high for exactly as many cycles as the burst is long. For a write burst, busy marks the cycles in which a write word is taken.

Top module: `burst_col_engine`

## Requirements
- R1: After synchronous reset, busy and rd_valid are low and the mode code is 0, so the first request after reset moves exactly one word.
- R2: The 2-bit mode code selects the burst length as 0→1, 1→2, 2→4, 3→8. A request taken while idle makes busy high for exactly that many cycles, starting in the cycle after the request edge.
- R3: beat_row equals the requested row in every beat of a burst.
- R4: The first beat's beat_col is the requested column. Each later beat adds one to the column inside the block of burst-length columns that holds the start, wrapping from the block's top column back to its lowest column.
- R5: In a read burst, rd_valid is high in exactly the busy cycles, and in each of them rd_data is the word stored at (beat_row, beat_col).
- R6: In a write burst, rd_valid stays low, and the wr_data present in each busy cycle is stored at that cycle's (beat_row, beat_col).
- R7: A request presented while busy is high has no effect. The running burst keeps its row, its column sequence and its length, and no burst follows it.
- R8: A mode load is ignored while busy is high, and also when a request is taken at the same edge. A load in an idle cycle with no request sets the length used by later requests.
- R9: With the mode code at 0, bursting is off. Each request gives one beat at the requested column, after which busy drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all transfers on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load mode_code into the mode register |
| mode_code | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8) |
| req_valid | input | 1 | Burst request strobe |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_row | input | ROW_W | Row to open for the burst |
| req_col | input | COL_W | Starting column |
| wr_data | input | DATA_W | Write word for the current beat |
| busy | output | 1 | A burst is in progress (one beat per cycle) |
| rd_valid | output | 1 | rd_data holds a read beat |
| beat_row | output | ROW_W | Row of the current beat |
| beat_col | output | COL_W | Column of the current beat |
| rd_data | output | DATA_W | Read word of the current beat |

## Verification
Bursts are run at every length. The start columns are aligned, unaligned, and at the top of a block, so a counter that crosses into the next block, or one that counts without wrapping, gives a column sequence that differs from the expected one. Write bursts fill the store with a value that depends on the address. Reading it back with a different length and start then separates a wrong write address from a wrong read address. Requests and mode loads that arrive during a burst, or at the same edge as a request, show whether the busy guard and the hold on the mode register do their job. Each such check observes the burst that follows.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    BL1 = 2'd0,
    BL2 = 2'd1,
    BL4 = 2'd2,
    BL8 = 2'd3
  } blen_e;

  // burst length minus one for a mode code; doubles as the wrap mask
  function automatic logic [3:0] blen_m1(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd0;
      2'd1:    return 4'd1;
      2'd2:    return 4'd3;
      default: return 4'd7;
    endcase
  endfunction
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg #(
  parameter int COL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             hold,
  input  logic [1:0]       code_in,
  output logic [1:0]       code_q,
  output logic [COL_W-1:0] mask
);
  import burst_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)
      code_q <= BL1;
    else if (load && !hold)
      code_q <= code_in;
  end

  assign mask = COL_W'(blen_m1(code_q));

  // R8: a hold blocks any change of the code
  a_r8_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(code_q));
endmodule

// File: rtl/burst_col_step.sv
module burst_col_step #(
  parameter int COL_W = 4
) (
  input  logic [COL_W-1:0] col_in,
  input  logic [COL_W-1:0] mask,
  output logic [COL_W-1:0] col_out
);
  // upper bits keep the aligned block, lower bits count modulo the length
  assign col_out = (col_in & ~mask) | ((col_in + COL_W'(1)) & mask);
endmodule

// File: rtl/burst_row_mem.sv
module burst_row_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/burst_col_engine.sv
module burst_col_engine #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_load,
  input  logic [1:0]        mode_code,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              rd_valid,
  output logic [ROW_W-1:0]  beat_row,
  output logic [COL_W-1:0]  beat_col,
  output logic [DATA_W-1:0] rd_data
);
  localparam int AW    = ROW_W + COL_W;
  localparam int CNT_W = 3;   // counts up to 7 remaining beats

  logic              busy_q, wr_q, rdv_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q, col_nx, mask;
  logic [CNT_W-1:0]  left_q;
  logic [1:0]        code_q;
  logic              accept, last;
  logic [AW-1:0]     raddr;

  assign accept = req_valid && !busy_q;
  assign last   = busy_q && (left_q == '0);

  burst_mode_reg #(.COL_W(COL_W)) mode_i (
    .clk     (clk),
    .rst     (rst),
    .load    (mode_load),
    .hold    (busy_q || accept),
    .code_in (mode_code),
    .code_q  (code_q),
    .mask    (mask)
  );

  burst_col_step #(.COL_W(COL_W)) step_i (
    .col_in  (col_q),
    .mask    (mask),
    .col_out (col_nx)
  );

  assign raddr = accept ? {req_row, req_col} : {row_q, col_nx};

  burst_row_mem #(.AW(AW), .DW(DATA_W)) mem_i (
    .clk   (clk),
    .we    (busy_q && wr_q),
    .waddr ({row_q, col_q}),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      rdv_q  <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      left_q <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      wr_q   <= req_write;
      rdv_q  <= !req_write;
      row_q  <= req_row;
      col_q  <= req_col;
      left_q <= mask[CNT_W-1:0];
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        rdv_q  <= 1'b0;
      end else begin
        left_q <= left_q - CNT_W'(1);
        col_q  <= col_nx;
      end
    end
  end

  assign busy     = busy_q;
  assign rd_valid = rdv_q;
  assign beat_row = row_q;
  assign beat_col = col_q;

  // R2: an accepted request starts a burst at the requested address
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy && beat_col == $past(req_col) && beat_row == $past(req_row));
  // R2: the final beat ends the burst
  a_r2_end: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy);
  // R3: the open row does not move within a burst
  a_r3_row_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> $stable(beat_row));
  // R4: each step moves the column but stays inside its aligned block
  a_r4_col_block: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> (((beat_col ^ $past(beat_col)) & ~mask) == '0)
                          && (beat_col != $past(beat_col)));
  // R5: read valid only during a read burst
  a_r5_valid_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy && !wr_q);
  // R7: a request during a burst does not reload the beat count
  a_r7_ignore_req: assert property (@(posedge clk) disable iff (rst)
    (busy_q && req_valid && !last) |=> left_q == $past(left_q) - CNT_W'(1));
endmodule

// File: tb/burst_col_engine_tb_top.sv
module burst_col_engine_tb_top;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int DATA_W = 16;
  localparam int COLS   = 1 << COL_W;
  localparam int ROWS   = 1 << ROW_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode_load = 1'b0;
  logic [1:0]        mode_code = 2'd0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              busy, rd_valid;
  logic [ROW_W-1:0]  beat_row;
  logic [COL_W-1:0]  beat_col;
  logic [DATA_W-1:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [DATA_W-1:0] model [ROWS*COLS];

  always #2 clk = ~clk;   // 250 MHz

  burst_col_engine #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_code(mode_code),
    .req_valid(req_valid), .req_write(req_write), .req_row(req_row),
    .req_col(req_col), .wr_data(wr_data), .busy(busy), .rd_valid(rd_valid),
    .beat_row(beat_row), .beat_col(beat_col), .rd_data(rd_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pat(input int row, input int col);
    return DATA_W'((row * 16'h0101) ^ (col * 16'h1111) ^ 16'h5A3C);
  endfunction

  task automatic load_mode(input int code);
    @(negedge clk);
    mode_load = 1'b1; mode_code = 2'(code);
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  // one burst; noise drives a foreign request during beats,
  // mnoise tries a mode load (code 0) in the first beat
  task automatic run_burst(input int row, input int col, input bit wr, input int len,
                           input bit noise, input bit mnoise);
    int base;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr;
    req_row = ROW_W'(row); req_col = COL_W'(col);
    @(negedge clk);
    req_valid = 1'b0;
    base = col & ~(len - 1);
    for (int k = 0; k < len; k++) begin
      int ec;
      ec = base | ((col + k) & (len - 1));
      chk(busy == 1'b1, "R2 busy during beat", int'(busy), 1);
      chk(rd_valid == !wr, wr ? "R6 rd_valid low on write" : "R5 rd_valid on read",
          int'(rd_valid), int'(!wr));
      chk(int'(beat_row) == row, "R3 row held", int'(beat_row), row);
      chk(int'(beat_col) == ec, "R4 column sequence", int'(beat_col), ec);
      if (wr) begin
        wr_data = pat(row, ec) ^ DATA_W'(len);
        model[row*COLS + ec] = wr_data;
      end else begin
        chk(rd_data == model[row*COLS + ec], "R5 read data",
            int'(rd_data), int'(model[row*COLS + ec]));
      end
      if (noise && k < len - 1) begin
        req_valid = 1'b1; req_write = !wr;
        req_row = ROW_W'(row ^ 5); req_col = COL_W'(col ^ 3);
      end else begin
        req_valid = 1'b0;
      end
      if (mnoise) begin
        mode_load = (k == 0); mode_code = 2'd0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0; mode_load = 1'b0;
    chk(busy == 1'b0, noise ? "R7 no burst after ignored request" : "R2 burst length",
        int'(busy), 0);
    chk(rd_valid == 1'b0, "R5 rd_valid ends with burst", int'(rd_valid), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);
    // R1 / R9: default mode means one beat per request
    run_burst(2, 9, 1'b1, 1, 1'b0, 1'b0);
    run_burst(2, 9, 1'b0, 1, 1'b0, 1'b0);
  endtask

  task automatic t_fill();
    load_mode(3);
    for (int r = 0; r < ROWS; r++) begin
      run_burst(r, 0, 1'b1, 8, 1'b0, 1'b0);   // R6
      run_burst(r, 8, 1'b1, 8, 1'b0, 1'b0);
    end
  endtask

  task automatic t_read_modes();
    for (int c = 0; c < 4; c++) begin
      load_mode(c);
      run_burst(c + 1, 5, 1'b0, 1 << c, 1'b0, 1'b0);   // R2 R4 R5
      run_burst(15 - c, 15, 1'b0, 1 << c, 1'b0, 1'b0);  // wrap from top
      run_burst(7, 8, 1'b0, 1 << c, 1'b0, 1'b0);        // aligned start
    end
    load_mode(0);
    run_burst(11, 14, 1'b0, 1, 1'b0, 1'b0);   // R9
  endtask

  task automatic t_busy_ignore();
    load_mode(2);
    run_burst(3, 6, 1'b0, 4, 1'b1, 1'b0);     // R7
    run_burst(4, 1, 1'b1, 4, 1'b1, 1'b0);     // R7 during a write
    run_burst(4, 0, 1'b0, 4, 1'b0, 1'b0);     // ignored requests wrote nothing
  endtask

  task automatic t_mode_ignore();
    load_mode(2);
    run_burst(6, 2, 1'b0, 4, 1'b0, 1'b1);     // R8 load during burst
    run_burst(6, 13, 1'b0, 4, 1'b0, 1'b0);    // still length 4
    // R8 load at the edge a request is taken
    @(negedge clk);
    mode_load = 1'b1; mode_code = 2'd3;
    req_valid = 1'b1; req_write = 1'b0; req_row = 4'd9; req_col = 4'd10;
    @(negedge clk);
    mode_load = 1'b0; req_valid = 1'b0;
    repeat (4) begin
      chk(busy == 1'b1, "R8 same-edge load ignored", int'(busy), 1);
      @(negedge clk);
    end
    chk(busy == 1'b0, "R8 same-edge load ignored", int'(busy), 0);
    run_burst(9, 1, 1'b0, 4, 1'b0, 1'b0);
    load_mode(1);                              // R8 idle load takes effect
    run_burst(12, 7, 1'b1, 2, 1'b0, 1'b0);
    load_mode(3);
    run_burst(12, 3, 1'b0, 8, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_read_modes();
    t_busy_ignore();
    t_mode_ignore();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule